// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is a configurable two-level logic plane. Twenty input signals each drive two array lines, one in true form and one inverted. A programmable AND plane forms 64 product terms from those 40 lines. A fixed OR plane then groups the terms by eight, one group per output cell, and produces eight sums. Which line feeds which term is set by a flat connection map. The map is captured into a register only while the load strobe is high. After that, the plane evaluates purely combinationally from the live inputs.

Each cell also brings its first term out on a separate output, so a neighbouring output stage can use it as an enable. When a cell's enable mode bit is set, that first term is removed from the cell's sum, and only the other seven terms are ORed. A term with no connections reads HIGH. A term that connects both forms of the same signal reads LOW.

Top module: `pla_sop_array`

## Requirements
- R1: Once a cycle with `rst_n` low has passed, the stored connection map is all zero. Until the next load, every `cell_sum` and `cell_first` bit is 1 for any `sig_in`.
- R2: Map bit `t*40 + c` set to 1 connects array column `c` to term `t`. Column `2*i` carries `sig_in[i]` and column `2*i+1` carries its inverse.
- R3: A term with no connected column evaluates to 1.
- R4: A term that connects both column `2*i` and column `2*i+1` evaluates to 0 for every input value.
- R5: With `oe_mode[k]` = 0, `cell_sum[k]` is the OR of terms `8k` through `8k+7`.
- R6: With `oe_mode[k]` = 1, `cell_sum[k]` is the OR of terms `8k+1` through `8k+7` only, so term `8k` cannot set it.
- R7: `cell_first[k]` equals term `8k` in both modes.
- R8: `cfg_fuse` is captured only at a rising clock edge with `cfg_load` high. Changes to `cfg_fuse` while `cfg_load` is low never reach the outputs.
- R9: The outputs follow `sig_in` and `oe_mode` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the connection-map register |
| rst_n | input | 1 | Synchronous active-low reset; clears the map |
| cfg_load | input | 1 | Captures `cfg_fuse` at the rising edge when high |
| cfg_fuse | input | 2560 | Flat connection map, bit `t*40+c` |
| sig_in | input | 20 | Array input signals |
| oe_mode | input | 8 | Per-cell enable mode: drop the first term from the sum |
| cell_sum | output | 8 | OR-plane result for each cell |
| cell_first | output | 8 | First product term of each cell |

## Verification
Sparse random maps, with about one bit in 24 set, are paired with random inputs and enable modes. This gives terms that are true for some inputs and false for others, so the sum and first-term outputs are compared against a bench model across a mix of outcomes. Directed maps isolate one term at a time:
- a single true column, which shows the column ordering;
- a single inverted column, which shows the inverse wiring;
- a both-polarity pair, which shows the forced LOW;
- an empty cell, which shows the default HIGH.

A cell whose only live term is its first term tells the two enable modes apart. A map change made without the load strobe, and an input change made without a clock edge, separate the register capture from the combinational path.

// File: rtl/pla_pkg.sv
// Shared sizing for the sum-of-products plane.
// Assumes two array columns per input signal (true, inverted).
package pla_pkg;
    localparam int unsigned SIG_COUNT      = 20;
    localparam int unsigned CELL_COUNT     = 8;
    localparam int unsigned TERMS_PER_CELL = 8;
endpackage

// File: rtl/pla_fuse_store.sv
// Connection-map register: holds the map, loaded only on a strobe.
// Assumes a synchronous active-low reset that clears every connection.
module pla_fuse_store #(
    parameter int unsigned MAP_W = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAP_W-1:0] map_in,
    output logic [MAP_W-1:0] map_q
);
    // Capture the map while loading, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= '0;
        else if (load)
            map_q <= map_in;
    end
endmodule

// File: rtl/pla_line_drive.sv
// Input buffers: each signal drives a true and an inverted array column.
// Assumes column 2i is true and column 2i+1 is inverted.
module pla_line_drive #(
    parameter int unsigned SIGS = 20,
    localparam int unsigned COLS = 2 * SIGS
) (
    input  logic [SIGS-1:0] sig,
    output logic [COLS-1:0] lines
);
    for (genvar i = 0; i < SIGS; i++) begin : g_buf
        assign lines[2*i]   = sig[i];
        assign lines[2*i+1] = ~sig[i];
    end
endmodule

// File: rtl/pla_and_plane.sv
// Programmable AND plane: each term is the AND of its connected columns.
// An empty term reads 1. Both polarities of one signal force the term to 0,
// because one of the two columns is always low.
module pla_and_plane #(
    parameter int unsigned COLS  = 40,
    parameter int unsigned TERMS = 64,
    localparam int unsigned MAP_W = COLS * TERMS
) (
    input  logic [MAP_W-1:0] map_q,
    input  logic [COLS-1:0]  lines,
    output logic [TERMS-1:0] terms
);
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic [COLS-1:0] conn;
        assign conn     = map_q[t*COLS +: COLS];
        // A connected column must be high; an unconnected column is ignored.
        assign terms[t] = &(~conn | lines);
    end
endmodule

// File: rtl/pla_or_plane.sv
// Fixed OR plane: groups terms per cell. The first term of each group is
// also exported, and it is left out of the sum when that cell's enable mode is set.
module pla_or_plane #(
    parameter int unsigned CELLS = 8,
    parameter int unsigned TPC   = 8,
    localparam int unsigned TERMS = CELLS * TPC
) (
    input  logic [TERMS-1:0] terms,
    input  logic [CELLS-1:0] oe_mode,
    output logic [CELLS-1:0] sums,
    output logic [CELLS-1:0] firsts
);
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        logic [TPC-1:0] grp;
        logic [TPC-1:0] mask;
        assign grp       = terms[k*TPC +: TPC];
        assign mask      = {{(TPC-1){1'b1}}, ~oe_mode[k]};
        assign sums[k]   = |(grp & mask);
        assign firsts[k] = grp[0];
    end
endmodule

// File: rtl/pla_sop_array.sv
// Top level of the sum-of-products plane: map register, input buffers,
// AND plane and OR plane. The outputs are combinational from sig_in, oe_mode
// and the stored map.
module pla_sop_array #(
    parameter int unsigned SIGS  = pla_pkg::SIG_COUNT,
    parameter int unsigned CELLS = pla_pkg::CELL_COUNT,
    parameter int unsigned TPC   = pla_pkg::TERMS_PER_CELL,
    localparam int unsigned COLS  = 2 * SIGS,
    localparam int unsigned TERMS = CELLS * TPC,
    localparam int unsigned MAP_W = COLS * TERMS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [MAP_W-1:0] cfg_fuse,
    input  logic [SIGS-1:0]  sig_in,
    input  logic [CELLS-1:0] oe_mode,
    output logic [CELLS-1:0] cell_sum,
    output logic [CELLS-1:0] cell_first
);
    logic [MAP_W-1:0] map_q;
    logic [COLS-1:0]  lines;
    logic [TERMS-1:0] terms;

    pla_fuse_store #(.MAP_W(MAP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .map_in(cfg_fuse), .map_q(map_q)
    );

    pla_line_drive #(.SIGS(SIGS)) u_lines (
        .sig(sig_in), .lines(lines)
    );

    pla_and_plane #(.COLS(COLS), .TERMS(TERMS)) u_and (
        .map_q(map_q), .lines(lines), .terms(terms)
    );

    pla_or_plane #(.CELLS(CELLS), .TPC(TPC)) u_or (
        .terms(terms), .oe_mode(oe_mode),
        .sums(cell_sum), .firsts(cell_first)
    );
endmodule

// File: rtl/pla_sop_array_chk.sv
// Property checker for pla_sop_array, attached with bind.
// It sees only the top-level ports.
module pla_sop_array_chk #(
    parameter int unsigned SIGS  = 20,
    parameter int unsigned CELLS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [SIGS-1:0]  sig_in,
    input logic [CELLS-1:0] oe_mode,
    input logic [CELLS-1:0] cell_sum,
    input logic [CELLS-1:0] cell_first
);
    // Set once a reset cycle is seen, cleared by any load: the map is still clear.
    logic clear_map = 1'b0;
    always_ff @(posedge clk) begin
        if (!rst_n)
            clear_map <= 1'b1;
        else if (cfg_load)
            clear_map <= 1'b0;
    end

    // R1, R3: a cleared map leaves every term and sum high.
    a_r1_clear_map_high: assert property (@(posedge clk) disable iff (!rst_n)
        clear_map |-> (cell_sum == '1 && cell_first == '1));

    // R8: with no load, no reset and steady inputs, the outputs hold.
    a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_load) && $stable(sig_in) && $stable(oe_mode))
        |-> ($stable(cell_sum) && $stable(cell_first)));

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        // R5: in normal mode a true first term makes the sum true.
        a_r5_first_in_sum: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_mode[k] && cell_first[k]) |-> cell_sum[k]);

        // R6: dropping the first term can never raise the sum.
        a_r6_drop_cannot_raise: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cfg_load) && $rose(oe_mode[k]) && $stable(sig_in))
            |-> !(cell_sum[k] && !$past(cell_sum[k])));
    end
endmodule

bind pla_sop_array pla_sop_array_chk #(.SIGS(SIGS), .CELLS(CELLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .sig_in(sig_in),
    .oe_mode(oe_mode), .cell_sum(cell_sum), .cell_first(cell_first)
);

// File: tb/pla_sop_array_test.sv
// Bench: random sparse maps plus directed corner cases, compared with a model.
module pla_sop_array_test;
    localparam int SIGS = 20, CELLS = 8, TPC = 8;
    localparam int COLS = 2 * SIGS, TERMS = CELLS * TPC, MAP_W = COLS * TERMS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [MAP_W-1:0] cfg_fuse = '0;
    logic [SIGS-1:0]  sig_in = '0;
    logic [CELLS-1:0] oe_mode = '0;
    logic [CELLS-1:0] cell_sum, cell_first;
    logic [MAP_W-1:0] ref_map = '0;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pla_sop_array uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fuse(cfg_fuse),
        .sig_in(sig_in), .oe_mode(oe_mode),
        .cell_sum(cell_sum), .cell_first(cell_first)
    );

    // Model of one term: every connected column must be high.
    function automatic logic term_val(input logic [MAP_W-1:0] m, input logic [SIGS-1:0] s, input int t);
        logic v = 1'b1;
        for (int c = 0; c < COLS; c++)
            if (m[t*COLS + c]) begin
                if ((c % 2) == 0 && !s[c/2]) v = 1'b0;
                if ((c % 2) == 1 &&  s[c/2]) v = 1'b0;
            end
        return v;
    endfunction

    function automatic logic [CELLS-1:0] exp_sum(input logic [MAP_W-1:0] m, input logic [SIGS-1:0] s, input logic [CELLS-1:0] oe);
        logic [CELLS-1:0] r = '0;
        for (int k = 0; k < CELLS; k++)
            for (int j = 0; j < TPC; j++)
                if (!(j == 0 && oe[k]) && term_val(m, s, k*TPC + j)) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic [CELLS-1:0] exp_first(input logic [MAP_W-1:0] m, input logic [SIGS-1:0] s);
        logic [CELLS-1:0] r;
        for (int k = 0; k < CELLS; k++) r[k] = term_val(m, s, k*TPC);
        return r;
    endfunction

    task automatic chk(input string req, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load_map(input logic [MAP_W-1:0] m);
        @(negedge clk);
        cfg_fuse = m; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        ref_map = m;
    endtask

    task automatic check_now(input string req);
        #1;
        chk({req, " sum"}, cell_sum, exp_sum(ref_map, sig_in, oe_mode));
        chk({req, " first"}, cell_first, exp_first(ref_map, sig_in));
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [MAP_W-1:0] m;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R3: cleared map gives all-high outputs.
        for (int i = 0; i < 4; i++) begin
            sig_in = SIGS'($urandom); oe_mode = CELLS'($urandom);
            #1;
            chk("R1 reset sum", cell_sum, '1);
            chk("R3 empty first", cell_first, '1);
        end

        // R2: term 0 on true sig 3, term 8 on inverted sig 5.
        m = '0;
        m[0*COLS + 2*3] = 1'b1;
        m[8*COLS + 2*5 + 1] = 1'b1;
        // R4: term 16 connects both forms of sig 3.
        m[16*COLS + 6] = 1'b1; m[16*COLS + 7] = 1'b1;
        // Every other term in cells 0..2 is forced low with a both-polarity pair; cell 3 is left empty.
        for (int t = 1; t < 24; t++)
            if (t != 8 && t != 16) begin m[t*COLS] = 1'b1; m[t*COLS + 1] = 1'b1; end
        for (int t = 32; t < TERMS; t++) begin m[t*COLS] = 1'b1; m[t*COLS + 1] = 1'b1; end
        load_map(m);
        oe_mode = '0;
        for (int v = 0; v < 4; v++) begin
            sig_in = '0; sig_in[3] = v[0]; sig_in[5] = v[1];
            #1;
            chk("R2 true column", CELLS'(cell_first[0]), CELLS'(v[0]));
            chk("R2 inverted column", CELLS'(cell_first[1]), CELLS'(!v[1]));
            chk("R4 both polarities", CELLS'(cell_first[2]), '0);
            chk("R3 empty cell", CELLS'(cell_sum[3]), CELLS'(1));
            chk("R5 sum with first", CELLS'(cell_sum[0]), CELLS'(v[0]));
        end

        // R6 R7: only term 0 is live in cell 0; the enable mode drops it.
        sig_in = '0; sig_in[3] = 1'b1; oe_mode = 8'h01;
        #1;
        chk("R6 first dropped", CELLS'(cell_sum[0]), '0);
        chk("R7 first still out", CELLS'(cell_first[0]), CELLS'(1));

        // R8: map change without load is ignored.
        oe_mode = '0;
        @(negedge clk);
        cfg_fuse = '0;
        repeat (2) @(negedge clk);
        check_now("R8 no load");

        // R9: inputs alone change outputs, no clock edge.
        @(negedge clk);
        sig_in[3] = 1'b0;
        check_now("R9 comb path");

        // R2 R5 R6 R7: random sparse maps.
        for (int r = 0; r < 25; r++) begin
            for (int b = 0; b < MAP_W; b++) m[b] = (($urandom % 24) == 0);
            load_map(m);
            for (int p = 0; p < 8; p++) begin
                sig_in = SIGS'($urandom); oe_mode = CELLS'($urandom);
                check_now("R5 R6 R7 random");
                #1;
            end
        end

        // R1: reset clears a loaded map.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ref_map = '0;
        check_now("R1 after reload reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule